// File: doc/BRIEF.md
# Shared Activation Lookup with Neighbour Fault Check

This block is the activation stage for a cluster of four neuron multiply-accumulate units. A request carries four accumulated sums at once. The block subtracts a per-neuron bias from each sum, clamps the difference into the range of a 1024-entry table, and returns the table entry as that neuron's activated output. The four neurons take turns through one lookup path, so the cluster needs only one table and one comparator.

The table is a single-port RAM of 32-bit words. It is written before use through a simple write strobe while the block is idle. Because the stored function is continuous, neighbouring entries should lie close together. Every lookup therefore also reads the entry below and the entry above the addressed one. If the addressed value is further than a programmable step limit from either neighbour, the error bit for that neuron is set. A corrupted entry that stays within the step limit is returned without a flag, on the grounds that it cannot move the result by much.

The control is a state machine. ST_IDLE accepts table writes or a request (transition accept). For each lane in order 0 to 3 it runs ST_FETCH_MID, ST_FETCH_LO, ST_FETCH_HI and ST_JUDGE. The transition next_lane goes from ST_JUDGE back to ST_FETCH_MID, and the transition last_lane goes to ST_PRESENT. ST_PRESENT holds the bundle until the consumer takes it (transition release) and then returns to ST_IDLE.

Top module: `act_lut_unit`

## Requirements
- R1: After reset, res_valid is 0 and req_ready is 1 while cfg_we is 0.
- R2: In ST_IDLE a high cfg_we writes cfg_data into table entry cfg_addr at the clock edge. While cfg_we is high, req_ready is 0.
- R3: A cfg_we pulse made while a request is in progress does not change the table.
- R4: The index for lane k is the signed difference of its sum and its bias, both two's complement 32-bit, saturated to 0 when negative and to 1023 when above 1023.
- R5: Lane k's result occupies res_values bits [32k+31:32k] and equals the table entry at its index.
- R6: res_err bit k is 1 when the unsigned absolute difference between the addressed entry and an existing neighbour is greater than step_limit.
- R7: An absolute difference equal to or less than step_limit raises no error, even when the entry was altered.
- R8: At index 0 only the entry above is compared, and at index 1023 only the entry below.
- R9: res_valid rises exactly 16 clock cycles after the edge that accepts a request (four cycles per lane).
- R10: While res_valid is 1 and res_ready is 0, res_values and res_err hold stable. A cycle with res_ready high ends the transfer, and res_valid is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Table write strobe, honoured in ST_IDLE only |
| cfg_addr | input | 10 | Table write address |
| cfg_data | input | 32 | Table write data |
| step_limit | input | 32 | Largest allowed neighbour difference |
| thr_flat | input | 128 | Four per-neuron biases, lane k at bits 32k |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_sums | input | 128 | Four accumulated sums, lane k at bits 32k |
| res_ready | input | 1 | Consumer takes the result bundle |
| res_valid | output | 1 | Result bundle valid |
| res_values | output | 128 | Four activated values, lane k at bits 32k |
| res_err | output | 4 | Neighbour check error, bit k for lane k |

## Verification
The assertions watch on every cycle that a held bundle stays stable under backpressure, that each bundle arrives exactly 16 cycles after acceptance, that negative offsets clamp the index to zero, and that a flat neighbourhood never raises an error. The table contents, the exact flagging of a corrupted entry and its neighbours, the step-limit equality boundary, the edge entries and the ignored write during a busy request can only be shown by the bench. It loads a known ramp, sweeps every index through all four lanes, and then plants faults.

// File: rtl/act_lut_pkg.sv
package act_lut_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_MID,
        ST_FETCH_LO,
        ST_FETCH_HI,
        ST_JUDGE,
        ST_PRESENT
    } act_state_e;

    localparam int CYCLES_PER_LANE = 4;

endpackage

// File: rtl/act_lut_ram.sv
module act_lut_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end

endmodule

// File: rtl/act_lut_index.sv
module act_lut_index #(
    parameter int LANES  = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10
) (
    input  logic [LANES*DATA_W-1:0] sums_flat,
    input  logic [LANES*DATA_W-1:0] bias_flat,
    output logic [LANES*ADDR_W-1:0] idx_flat
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic signed [DATA_W:0] TOP_VAL = (DATA_W+1)'(DEPTH - 1);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DATA_W-1:0]        s_w;
        logic [DATA_W-1:0]        b_w;
        logic signed [DATA_W:0]   diff_w;
        logic [ADDR_W-1:0]        idx_w;

        assign s_w = sums_flat[g*DATA_W +: DATA_W];
        assign b_w = bias_flat[g*DATA_W +: DATA_W];

        always_comb begin
            diff_w = $signed({s_w[DATA_W-1], s_w}) - $signed({b_w[DATA_W-1], b_w});
            if (diff_w < 0) begin
                idx_w = '0;
            end else if (diff_w > TOP_VAL) begin
                idx_w = '1;
            end else begin
                idx_w = diff_w[ADDR_W-1:0];
            end
        end

        assign idx_flat[g*ADDR_W +: ADDR_W] = idx_w;
    end

endmodule

// File: rtl/act_lut_judge.sv
module act_lut_judge #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] idx,
    input  logic [DATA_W-1:0] mid,
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    input  logic [DATA_W-1:0] step,
    output logic              err
);
    logic              has_lo;
    logic              has_hi;
    logic [DATA_W-1:0] gap_lo;
    logic [DATA_W-1:0] gap_hi;

    always_comb begin
        has_lo = (idx != '0);
        has_hi = (idx != '1);
        gap_lo = (mid > lo) ? (mid - lo) : (lo - mid);
        gap_hi = (mid > hi) ? (mid - hi) : (hi - mid);
        err    = (has_lo && (gap_lo > step)) || (has_hi && (gap_hi > step));
    end

endmodule

// File: rtl/act_lut_unit.sv
module act_lut_unit
    import act_lut_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [DATA_W-1:0]       cfg_data,
    input  logic [DATA_W-1:0]       step_limit,
    input  logic [LANES*DATA_W-1:0] thr_flat,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES*DATA_W-1:0] req_sums,
    input  logic                    res_ready,
    output logic                    res_valid,
    output logic [LANES*DATA_W-1:0] res_values,
    output logic [LANES-1:0]        res_err
);
    localparam int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int LATENCY = LANES * CYCLES_PER_LANE;
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    act_state_e st_q, st_d;

    logic [LANE_W-1:0]       lane_q;
    logic [ADDR_W-1:0]       idx_q [LANES];
    logic [LANES*ADDR_W-1:0] idx_flat;
    logic [DATA_W-1:0]       mid_q;
    logic [DATA_W-1:0]       lo_q;
    logic [DATA_W-1:0]       ram_rdata;
    logic [ADDR_W-1:0]       ram_addr;
    logic                    ram_we;
    logic [ADDR_W-1:0]       cur_idx;
    logic                    lane_err;
    logic                    accept;
    logic [LANES*DATA_W-1:0] values_q;
    logic [LANES-1:0]        err_q;

    act_lut_index #(
        .LANES (LANES),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_index (
        .sums_flat(req_sums),
        .bias_flat(thr_flat),
        .idx_flat (idx_flat)
    );

    act_lut_ram #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .addr (ram_addr),
        .wdata(cfg_data),
        .rdata(ram_rdata)
    );

    act_lut_judge #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_judge (
        .idx (cur_idx),
        .mid (mid_q),
        .lo  (lo_q),
        .hi  (ram_rdata),
        .step(step_limit),
        .err (lane_err)
    );

    assign cur_idx = idx_q[lane_q];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:      if (accept) st_d = ST_FETCH_MID;
            ST_FETCH_MID: st_d = ST_FETCH_LO;
            ST_FETCH_LO:  st_d = ST_FETCH_HI;
            ST_FETCH_HI:  st_d = ST_JUDGE;
            ST_JUDGE:     st_d = (lane_q == LAST_LANE) ? ST_PRESENT : ST_FETCH_MID;
            ST_PRESENT:   if (res_ready) st_d = ST_IDLE;
            default:      st_d = ST_IDLE;
        endcase
    end

    // Outputs and RAM control
    always_comb begin
        req_ready = 1'b0;
        res_valid = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = cfg_addr;
        unique case (st_q)
            ST_IDLE: begin
                req_ready = !cfg_we;
                ram_we    = cfg_we;
            end
            ST_FETCH_MID: ram_addr = cur_idx;
            ST_FETCH_LO:  ram_addr = (cur_idx == '0) ? cur_idx : cur_idx - 1'b1;
            ST_FETCH_HI:  ram_addr = (cur_idx == '1) ? cur_idx : cur_idx + 1'b1;
            ST_JUDGE:     ram_addr = cur_idx;
            ST_PRESENT:   res_valid = 1'b1;
            default:      ram_addr = cfg_addr;
        endcase
    end

    assign accept     = req_valid && req_ready;
    assign res_values = values_q;
    assign res_err    = err_q;

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q   <= '0;
            mid_q    <= '0;
            lo_q     <= '0;
            values_q <= '0;
            err_q    <= '0;
            for (int i = 0; i < LANES; i++) begin
                idx_q[i] <= '0;
            end
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        lane_q <= '0;
                        err_q  <= '0;
                        for (int i = 0; i < LANES; i++) begin
                            idx_q[i] <= idx_flat[i*ADDR_W +: ADDR_W];
                        end
                    end
                end
                ST_FETCH_LO: mid_q <= ram_rdata;
                ST_FETCH_HI: lo_q  <= ram_rdata;
                ST_JUDGE: begin
                    values_q[lane_q*DATA_W +: DATA_W] <= mid_q;
                    err_q[lane_q] <= lane_err;
                    lane_q <= lane_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Latency watch counter for the assertion
    logic [CNT_W-1:0] lat_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_cnt <= '0;
        end else if (accept) begin
            lat_cnt <= '0;
        end else if (!res_valid && lat_cnt != '1) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    a_r9_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> (lat_cnt == CNT_W'(LATENCY)));

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_values) && $stable(res_err)));

    a_r6_flat_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_JUDGE && lo_q == mid_q && ram_rdata == mid_q) |-> !lane_err);

    a_r3_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |-> !ram_we);

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        a_r4_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && ($signed(req_sums[g*DATA_W +: DATA_W]) < $signed(thr_flat[g*DATA_W +: DATA_W])))
            |=> (idx_q[g] == '0));
    end

endmodule

// File: tb/act_lut_unit_test.sv
module act_lut_unit_test;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [9:0]        cfg_addr = '0;
    logic [31:0]       cfg_data = '0;
    logic [31:0]       step_limit = 32'd3;
    logic [3:0][31:0]  thr = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [3:0][31:0]  req_sums = '0;
    logic              res_ready = 1'b0;
    logic              res_valid;
    logic [127:0]      res_values;
    logic [3:0]        res_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [31:0] tbl [1024];

    always #10 clk = ~clk;

    act_lut_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .step_limit(step_limit), .thr_flat(thr),
        .req_valid(req_valid), .req_ready(req_ready), .req_sums(req_sums),
        .res_ready(res_ready), .res_valid(res_valid), .res_values(res_values),
        .res_err(res_err)
    );

    function automatic logic [31:0] ramp(input int i);
        return 32'(100 + 3 * i);
    endfunction

    function automatic int exp_idx(input logic [31:0] s, input logic [31:0] t);
        longint d;
        d = longint'($signed(s)) - longint'($signed(t));
        if (d < 0) return 0;
        if (d > 1023) return 1023;
        return int'(d);
    endfunction

    function automatic logic [31:0] gap(input logic [31:0] a, input logic [31:0] b);
        return (a > b) ? a - b : b - a;
    endfunction

    function automatic logic exp_err(input int i);
        logic e = 1'b0;
        if (i > 0 && gap(tbl[i], tbl[i-1]) > step_limit) e = 1'b1;
        if (i < 1023 && gap(tbl[i], tbl[i+1]) > step_limit) e = 1'b1;
        return e;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int a, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 10'(a); cfg_data = v;
        #1;
        if (a == 0) chk("R2 ready low during write", 32'(req_ready), 32'd0);
        @(negedge clk);
        cfg_we = 1'b0;
        tbl[a] = v;
    endtask

    task automatic lookup(input logic [3:0][31:0] s, input int hold, input string etag);
        int cnt;
        int ix;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_sums = s;
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 0;
        while (!res_valid && cnt < 100) begin
            @(negedge clk);
            cnt++;
        end
        chk("R9 latency", 32'(cnt), 32'd16);
        repeat (hold) begin
            @(negedge clk);
            chk("R10 valid held", 32'(res_valid), 32'd1);
        end
        for (int k = 0; k < 4; k++) begin
            ix = exp_idx(s[k], thr[k]);
            chk("R5 R4 value", res_values[k*32 +: 32], tbl[ix]);
            if (ix == 0 || ix == 1023)
                chk("R8 edge err", 32'(res_err[k]), 32'(exp_err(ix)));
            else
                chk(etag, 32'(res_err[k]), 32'(exp_err(ix)));
        end
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk("R10 released", 32'(res_valid), 32'd0);
    endtask

    function automatic logic [3:0][31:0] at_idx(input int a, input int b, input int c, input int d);
        logic [3:0][31:0] r;
        r[0] = 32'(a) + thr[0]; r[1] = 32'(b) + thr[1];
        r[2] = 32'(c) + thr[2]; r[3] = 32'(d) + thr[3];
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset valid", 32'(res_valid), 32'd0);
        chk("R1 reset ready", 32'(req_ready), 32'd1);

        for (int i = 0; i < 1024; i++) cfg_write(i, ramp(i));

        // Full sweep with distinct biases per lane
        thr[0] = 32'd0; thr[1] = 32'd1000; thr[2] = -32'sd50; thr[3] = 32'd7;
        step_limit = 32'd3;
        for (int b = 0; b < 256; b++)
            lookup(at_idx(4*b, 4*b+1, 4*b+2, 4*b+3), 0, "R7 ramp within limit");

        // Saturation cases
        lookup({32'h8000_0000, 32'h7fff_ffff, 32'd0, -32'sd5}, 0, "R4 clamp");
        lookup({32'd1030, 32'd973, 32'd2023, 32'd1023}, 0, "R4 clamp high");

        // Tight limit flags every lookup
        step_limit = 32'd2;
        lookup(at_idx(0, 1, 512, 1023), 0, "R6 tight limit");

        // Planted faults
        step_limit = 32'd3;
        cfg_write(500, ramp(500) + 32'd10);
        lookup(at_idx(498, 499, 500, 501), 0, "R6 fault neighbourhood");
        lookup(at_idx(502, 497, 250, 750), 0, "R6 clean entries");
        step_limit = 32'd5;
        cfg_write(600, ramp(600) + 32'd2);
        cfg_write(700, ramp(700) + 32'd3);
        lookup(at_idx(599, 600, 601, 699), 0, "R7 equal limit");
        lookup(at_idx(700, 701, 600, 698), 0, "R6 over limit");

        // Write during a busy request is ignored
        fork
            lookup(at_idx(10, 11, 12, 13), 0, "R6 busy run");
            begin
                repeat (5) @(negedge clk);
                cfg_we = 1'b1; cfg_addr = 10'd10; cfg_data = 32'hdead;
                @(negedge clk);
                cfg_we = 1'b0;
            end
        join
        lookup(at_idx(10, 10, 10, 10), 0, "R3 table unchanged");

        // Backpressure
        lookup(at_idx(300, 301, 302, 303), 5, "R10 backpressure");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule